// File: doc/BRIEF.md
# Lane Predicate Vote and Ballot Unit

This unit accepts one predicate bit per lane for a group of lanes that run in lockstep. It takes an optional inversion control and a mask that marks which lanes take part. From the adjusted predicate vector it forms a ballot word with one bit per lane. It also forms a single reduced verdict, chosen from "every lane true", "some lane true" and "lanes agree". The caller broadcasts that verdict to every lane.

One operation is accepted per cycle on a valid strobe. The ballot and the verdict appear together, registered, on the cycle after the strobe, marked by an output valid. The caller writes the ballot to a general register and the verdict to a predicate register. Both of those stores are outside this block.

Top module: `lane_vote_unit`

## Requirements
- R1: When `inv_i` is 1, each lane's predicate is inverted before it is used for the ballot or the vote. When `inv_i` is 0, the predicate is used as given.
- R2: Bit i of `ballot_o` equals the adjusted predicate of lane i AND `lanes_i[i]`. Inactive lanes read as 0.
- R3: With `mode_i` = 2'b00, `verdict_o` is 1 exactly when every active lane's adjusted predicate is 1.
- R4: With `mode_i` = 2'b01, `verdict_o` is 1 exactly when at least one active lane's adjusted predicate is 1.
- R5: With `mode_i` = 2'b10, `verdict_o` is 1 exactly when all active lanes hold the same adjusted predicate value.
- R6: `mode_i` = 2'b11 behaves exactly like 2'b00.
- R7: With `lanes_i` all zero, the verdict is 1 for modes 00, 10 and 11 and 0 for mode 01. The ballot is 0.
- R8: `out_valid_o` is 1 in the cycle after a cycle with `in_valid_i` = 1, and 0 otherwise. `ballot_o` and `verdict_o` change only when `out_valid_o` rises or stays high after a new strobe.
- R9: A synchronous reset (`rst_i` = 1) clears `out_valid_o`, `ballot_o` and `verdict_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operation strobe |
| pred_i | input | 32 | Per-lane predicate bits |
| inv_i | input | 1 | Invert predicates before use |
| lanes_i | input | 32 | Active-lane mask |
| mode_i | input | 2 | 00 all, 01 any, 10 equal, 11 all |
| out_valid_o | output | 1 | Result valid, one cycle after strobe |
| ballot_o | output | 32 | Masked adjusted predicate word |
| verdict_o | output | 1 | Reduced vote result |

## Verification
The assertions assume that `pred_i`, `inv_i`, `lanes_i` and `mode_i` are known and stable around every clock edge where `in_valid_i` is high. Values sampled there are compared with the outputs one cycle later. The bench changes inputs only on the falling edge, so every edge sees settled values. The bench also keeps `in_valid_i` low during reset, except in a single case that checks that reset takes priority.

// File: rtl/lane_vote_pkg.sv
package lane_vote_pkg;
  localparam int LANES = 32;
  typedef enum logic [1:0] {
    VOTE_ALL   = 2'b00,
    VOTE_ANY   = 2'b01,
    VOTE_EQUAL = 2'b10,
    VOTE_ALT   = 2'b11
  } vote_mode_e;
endpackage

// File: rtl/lane_vote_reduce.sv
module lane_vote_reduce #(
  parameter int N = 32
) (
  input  logic [N-1:0] bits_i,
  input  logic [N-1:0] act_i,
  input  logic [1:0]   mode_i,
  output logic         verdict_o,
  output logic         all_w,
  output logic         any_w,
  output logic         eq_w
);
  function automatic logic f_all(input logic [N-1:0] b, input logic [N-1:0] a);
    return &(b | ~a);
  endfunction
  function automatic logic f_any(input logic [N-1:0] b, input logic [N-1:0] a);
    return |(b & a);
  endfunction

  always_comb begin
    all_w = f_all(bits_i, act_i);
    any_w = f_any(bits_i, act_i);
    eq_w  = all_w | ~any_w;
    case (mode_i)
      2'b01:   verdict_o = any_w;
      2'b10:   verdict_o = eq_w;
      default: verdict_o = all_w;
    endcase
  end
endmodule

// File: rtl/lane_vote_unit.sv
module lane_vote_unit
  import lane_vote_pkg::*;
#(
  parameter int N = LANES
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         in_valid_i,
  input  logic [N-1:0] pred_i,
  input  logic         inv_i,
  input  logic [N-1:0] lanes_i,
  input  logic [1:0]   mode_i,
  output logic         out_valid_o,
  output logic [N-1:0] ballot_o,
  output logic         verdict_o
);
  logic [N-1:0] adj_w;
  logic [N-1:0] ballot_w;
  logic         verdict_w, all_w, any_w, eq_w;

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign adj_w[g]    = pred_i[g] ^ inv_i;
    assign ballot_w[g] = adj_w[g] & lanes_i[g];
  end

  lane_vote_reduce #(.N(N)) u_red (
    .bits_i(adj_w), .act_i(lanes_i), .mode_i(mode_i),
    .verdict_o(verdict_w), .all_w(all_w), .any_w(any_w), .eq_w(eq_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_valid_o <= 1'b0;
      ballot_o    <= '0;
      verdict_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        ballot_o  <= ballot_w;
        verdict_o <= verdict_w;
      end
    end
  end
endmodule

// File: rtl/lane_vote_checker.sv
module lane_vote_checker #(
  parameter int N = 32
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         in_valid_i,
  input logic [N-1:0] pred_i,
  input logic         inv_i,
  input logic [N-1:0] lanes_i,
  input logic [1:0]   mode_i,
  input logic         out_valid_o,
  input logic [N-1:0] ballot_o,
  input logic         verdict_o
);
  assert_ballot_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i |=> ballot_o == (($past(pred_i) ^ {N{$past(inv_i)}}) & $past(lanes_i)));
  assert_inactive_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i |=> (ballot_o & ~$past(lanes_i)) == '0);
  assert_all_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && mode_i == 2'b00) |=> verdict_o == (ballot_o == $past(lanes_i)));
  assert_any_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && mode_i == 2'b01) |=> verdict_o == (ballot_o != '0));
  assert_equal_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && mode_i == 2'b10) |=>
      verdict_o == (ballot_o == '0 || ballot_o == $past(lanes_i)));
  assert_alt_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && mode_i == 2'b11) |=> verdict_o == (ballot_o == $past(lanes_i)));
  assert_valid_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i |=> out_valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> (!out_valid_o && $stable(ballot_o) && $stable(verdict_o)));
  assert_reset_R9: assert property (@(posedge clk_i)
    rst_i |=> (!out_valid_o && ballot_o == '0 && !verdict_o));
endmodule

bind lane_vote_unit lane_vote_checker #(.N(N)) u_chk (.*);

// File: tb/lane_vote_unit_test.sv
module lane_vote_unit_test;
  logic        clk_i = 0, rst_i = 1, in_valid_i = 0, inv_i = 0;
  logic [31:0] pred_i = 0, lanes_i = 0;
  logic [1:0]  mode_i = 0;
  logic        out_valid_o, verdict_o;
  logic [31:0] ballot_o;
  int checks = 0, errors = 0;

  lane_vote_unit uut (.*);
  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one op on the falling edge, then sample on the next falling edge.
  task automatic op(input logic [31:0] p, input logic n, input logic [31:0] m,
                    input logic [1:0] md);
    @(negedge clk_i);
    pred_i = p; inv_i = n; lanes_i = m; mode_i = md; in_valid_i = 1;
    @(negedge clk_i);
    in_valid_i = 0;
  endtask

  function automatic logic ref_v(input logic [31:0] p, input logic n,
                                 input logic [31:0] m, input logic [1:0] md);
    int ones = 0, act = 0;
    for (int i = 0; i < 32; i++) if (m[i]) begin
      act++;
      if (p[i] ^ n) ones++;
    end
    if (md == 2'b01) return ones > 0;
    if (md == 2'b10) return (ones == 0) || (ones == act);
    return ones == act;
  endfunction

  task automatic t_reset;
    chk("R9 valid", {31'b0, out_valid_o}, 0);
    chk("R9 ballot", ballot_o, 0);
    chk("R9 verdict", {31'b0, verdict_o}, 0);
  endtask

  task automatic t_ballot;
    op(32'hA5A5_0F0F, 0, 32'hFFFF_FFFF, 2'b00);
    chk("R2 ballot full", ballot_o, 32'hA5A5_0F0F);
    chk("R8 valid", {31'b0, out_valid_o}, 1);
    op(32'hA5A5_0F0F, 1, 32'hFFFF_FFFF, 2'b00);
    chk("R1 negated ballot", ballot_o, 32'h5A5A_F0F0);
    op(32'hFFFF_FFFF, 0, 32'h0000_FF00, 2'b01);
    chk("R2 masked ballot", ballot_o, 32'h0000_FF00);
  endtask

  task automatic t_modes;
    logic [31:0] ps [4] = '{32'hFFFF_FFFF, 32'h0, 32'h0000_0001, 32'h00FF_0000};
    logic [31:0] ms [3] = '{32'hFFFF_FFFF, 32'h00FF_0000, 32'h0000_0001};
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 3; b++)
        for (int md = 0; md < 4; md++)
          for (int n = 0; n < 2; n++) begin
            op(ps[a], n[0], ms[b], md[1:0]);
            chk(md == 0 ? "R3 all" : md == 1 ? "R4 any" : md == 2 ? "R5 equal" : "R6 alt",
                {31'b0, verdict_o}, {31'b0, ref_v(ps[a], n[0], ms[b], md[1:0])});
          end
  endtask

  task automatic t_specific;
    op(32'h0000_00FF, 0, 32'h0000_00FF, 2'b00);
    chk("R3 all true on active only", {31'b0, verdict_o}, 1);
    op(32'hFFFF_FFFE, 0, 32'hFFFF_FFFF, 2'b11);
    chk("R6 alt one lane false", {31'b0, verdict_o}, 0);
    op(32'h0, 1, 32'hFFFF_FFFF, 2'b10);
    chk("R5 equal all negated", {31'b0, verdict_o}, 1);
    op(32'h0000_0003, 0, 32'h0000_0006, 2'b10);
    chk("R5 equal disagree", {31'b0, verdict_o}, 0);
    op(32'h8000_0000, 0, 32'h7FFF_FFFF, 2'b01);
    chk("R4 any ignores inactive", {31'b0, verdict_o}, 0);
  endtask

  task automatic t_empty;
    for (int md = 0; md < 4; md++) begin
      op(32'hFFFF_FFFF, 0, 32'h0, md[1:0]);
      chk("R7 empty verdict", {31'b0, verdict_o}, md == 1 ? 0 : 1);
      chk("R7 empty ballot", ballot_o, 0);
    end
  endtask

  task automatic t_hold;
    op(32'h1234_5678, 0, 32'hFFFF_FFFF, 2'b01);
    @(negedge clk_i);
    pred_i = 32'hDEAD_BEEF; mode_i = 2'b00;
    @(negedge clk_i);
    chk("R8 valid low", {31'b0, out_valid_o}, 0);
    chk("R8 ballot held", ballot_o, 32'h1234_5678);
    chk("R8 verdict held", {31'b0, verdict_o}, 1);
  endtask

  task automatic t_rst_prio;
    @(negedge clk_i);
    rst_i = 1; in_valid_i = 1; pred_i = 32'hFFFF_FFFF; lanes_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    rst_i = 0; in_valid_i = 0;
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_i = 0;
    t_ballot();
    t_modes();
    t_specific();
    t_empty();
    t_hold();
    t_rst_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule